// File: doc/BRIEF.md
# Multithreaded Issue Selector

This block decides, cycle by cycle, which hardware thread may issue into a scalar in-order pipeline. It carries up to `NUM_THR` threads and supports two scheduling policies chosen by a mode input. In the per-cycle rotation policy the grant moves to another thread on every clock. In the run-until-stall policy the granted thread keeps the pipeline until it reports a long-latency event, such as a cache miss. In both policies the selector passes over threads that are not ready or that report a stall.

The decision is registered. Inputs sampled at a rising edge choose the grant that is visible during the following cycle. A thread that raised a latency event is parked and stays out of selection until its stall input is seen low. The selector also emits a one-cycle pulse whenever the granted thread differs from the last thread that issued, so that a downstream context mux can swap state.

Top module: `thread_issue_sel`

## Requirements
- R1: At most one bit of `issue_sel` is high in any cycle. `issue_sel` is nonzero exactly when `issue_vld` is high, and bit i selects thread i.
- R2: With `policy_blk`=0, each edge grants the first eligible thread in round-robin order, starting at the thread after the last one that issued. The last-issued index resets to `NUM_THR-1`, so the first grant after reset goes to the lowest eligible index.
- R3: A thread is eligible at an edge only if its `thr_ready` bit is 1 and its `thr_stall` bit is 0 at that edge. An ineligible thread is never granted.
- R4: With `policy_blk`=1, the thread granted in the current cycle is granted again at the next edge whenever it is still eligible and `lat_event` is low.
- R5: With `policy_blk`=1, a `lat_event` during a granted cycle moves the grant to the next eligible thread in round-robin order after the current one.
- R6: In either policy, a `lat_event` during a granted cycle excludes the running thread at that edge. The thread also stays excluded at every later edge up to and including the first edge at which its `thr_stall` is 0.
- R7: When no thread is eligible, `issue_vld` is 0 and `issue_sel` is 0 for that cycle, and the last-issued index is kept.
- R8: `ctx_switch` is 1 for exactly those cycles in which `issue_vld` is 1 and the granted index differs from the last-issued index.
- R9: During and right after synchronous reset, `issue_sel`, `issue_vld` and `ctx_switch` are all 0.
- R10: `lat_event` is ignored in any cycle in which `issue_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| policy_blk | input | 1 | 0 = rotate every cycle, 1 = run until latency event |
| thr_ready | input | NUM_THR | Per-thread has-work flags |
| thr_stall | input | NUM_THR | Per-thread stall (blocked) flags |
| lat_event | input | 1 | Long-latency event raised by the granted thread |
| issue_sel | output | NUM_THR | One-hot grant |
| issue_vld | output | 1 | A thread issues this cycle |
| ctx_switch | output | 1 | Grant differs from last issued thread |

## Verification
The bench targets the following corner cases:
- Rotation that has to jump over a stalled or idle thread. A selector that ignored eligibility would grant a stalled thread.
- A single eligible thread under rotation. A design that forced a change on every cycle would go idle or pulse `ctx_switch` when it should not.
- A park that must last one extra edge after the stall input clears. A design that ignored the park would regrant the thread too early.
- An idle gap followed by a resume. A design that lost the last-issued index would restart at the wrong thread or emit a false switch pulse.
- A latency event raised while nothing issues. A design that honoured it would park a thread that never ran.

// File: rtl/thr_sel_pkg.sv
package thr_sel_pkg;

    typedef enum logic {
        POL_ROTATE = 1'b0,
        POL_RUN    = 1'b1
    } issue_pol_e;

    typedef struct packed {
        logic       vld;
        logic [7:0] idx;
    } grant_t;

    function automatic logic [7:0] wrap_idx(input int unsigned base, input int unsigned step,
                                            input int unsigned n);
        int unsigned s;
        s = base + step;
        if (s >= n) s = s - n;
        return 8'(s);
    endfunction

endpackage

// File: rtl/thr_elig_track.sv
module thr_elig_track #(
    parameter int NUM_THR = 4,
    localparam int IW = $clog2(NUM_THR)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_THR-1:0] ready,
    input  logic [NUM_THR-1:0] stall,
    input  logic               evt_hit,
    input  logic [IW-1:0]      evt_idx,
    output logic [NUM_THR-1:0] elig
);
    logic [NUM_THR-1:0] parked_q;
    logic [NUM_THR-1:0] park_set;

    for (genvar i = 0; i < NUM_THR; i++) begin : g_thr
        assign park_set[i] = evt_hit && (evt_idx == IW'(i));
        assign elig[i]     = ready[i] && !stall[i] && !parked_q[i] && !park_set[i];

        always_ff @(posedge clk) begin
            if (rst) parked_q[i] <= 1'b0;
            else     parked_q[i] <= park_set[i] || (parked_q[i] && stall[i]);
        end

        // R6: the edge after an event still excludes that thread
        p_park_hold_r6: assert property (@(posedge clk) disable iff (rst)
            $past(park_set[i]) |-> !elig[i]);
    end
endmodule

// File: rtl/thr_rr_pick.sv
module thr_rr_pick
    import thr_sel_pkg::*;
#(
    parameter int NUM_THR = 4,
    localparam int IW = $clog2(NUM_THR)
) (
    input  logic [NUM_THR-1:0] elig,
    input  logic [IW-1:0]      start_idx,
    output logic               found,
    output logic [IW-1:0]      pick_idx
);
    always_comb begin
        found    = 1'b0;
        pick_idx = start_idx;
        for (int k = NUM_THR; k >= 1; k--) begin
            logic [7:0] cand;
            cand = wrap_idx(int'(start_idx), k, NUM_THR);
            if (elig[cand[IW-1:0]]) begin
                found    = 1'b1;
                pick_idx = cand[IW-1:0];
            end
        end
    end
endmodule

// File: rtl/thread_issue_sel.sv
module thread_issue_sel
    import thr_sel_pkg::*;
#(
    parameter int NUM_THR = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               policy_blk,
    input  logic [NUM_THR-1:0] thr_ready,
    input  logic [NUM_THR-1:0] thr_stall,
    input  logic               lat_event,
    output logic [NUM_THR-1:0] issue_sel,
    output logic               issue_vld,
    output logic               ctx_switch
);
    localparam int IW = $clog2(NUM_THR);

    issue_pol_e         pol;
    logic [IW-1:0]      cur_idx_q;
    logic               vld_q;
    logic               ctx_q;
    logic [NUM_THR-1:0] elig_w;
    logic               rr_found;
    logic [IW-1:0]      rr_idx;
    logic               keep_cur;
    grant_t             nxt;

    assign pol = issue_pol_e'(policy_blk);

    thr_elig_track #(.NUM_THR(NUM_THR)) u_elig (
        .clk     (clk),
        .rst     (rst),
        .ready   (thr_ready),
        .stall   (thr_stall),
        .evt_hit (lat_event && vld_q),
        .evt_idx (cur_idx_q),
        .elig    (elig_w)
    );

    thr_rr_pick #(.NUM_THR(NUM_THR)) u_pick (
        .elig      (elig_w),
        .start_idx (cur_idx_q),
        .found     (rr_found),
        .pick_idx  (rr_idx)
    );

    assign keep_cur = (pol == POL_RUN) && vld_q && !lat_event && elig_w[cur_idx_q];

    always_comb begin
        nxt = '0;
        if (keep_cur) begin
            nxt.vld = 1'b1;
            nxt.idx = 8'(cur_idx_q);
        end else if (rr_found) begin
            nxt.vld = 1'b1;
            nxt.idx = 8'(rr_idx);
        end else begin
            nxt.vld = 1'b0;
            nxt.idx = 8'(cur_idx_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_idx_q <= IW'(NUM_THR - 1);
            vld_q     <= 1'b0;
            ctx_q     <= 1'b0;
        end else begin
            cur_idx_q <= nxt.idx[IW-1:0];
            vld_q     <= nxt.vld;
            ctx_q     <= nxt.vld && (nxt.idx[IW-1:0] != cur_idx_q);
        end
    end

    for (genvar i = 0; i < NUM_THR; i++) begin : g_sel
        assign issue_sel[i] = vld_q && (cur_idx_q == IW'(i));
    end
    assign issue_vld  = vld_q;
    assign ctx_switch = ctx_q;

    // R1: single grant, consistent with valid
    p_single_grant_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(issue_sel) && (issue_vld == (issue_sel != '0)));

    // R3: granted thread was ready and unstalled when chosen
    p_grant_eligible_r3: assert property (@(posedge clk) disable iff (rst)
        issue_vld |-> (($past(thr_ready & ~thr_stall) & issue_sel) != '0));

    // R2: rotation with two or more candidates always changes thread
    p_rotate_moves_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(!policy_blk) && $past(issue_vld) && $past($countones(elig_w) > 1))
        |-> ctx_switch);

    // R4: run policy holds an eligible, event-free thread
    p_run_holds_r4: assert property (@(posedge clk) disable iff (rst)
        $past(policy_blk && issue_vld && !lat_event && ((elig_w & issue_sel) != '0))
        |-> (issue_vld && issue_sel == $past(issue_sel)));

    // R8: switch pulse only on an issuing cycle
    p_switch_needs_issue_r8: assert property (@(posedge clk) disable iff (rst)
        ctx_switch |-> issue_vld);
endmodule

// File: tb/test_thread_issue_sel.sv
module test_thread_issue_sel;
    logic       clk = 1'b0;
    logic       rst;
    logic       policy_blk;
    logic [3:0] thr_ready;
    logic [3:0] thr_stall;
    logic       lat_event;
    logic [3:0] issue_sel;
    logic       issue_vld;
    logic       ctx_switch;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    thread_issue_sel #(.NUM_THR(4)) i_thread_issue_sel (
        .clk        (clk),
        .rst        (rst),
        .policy_blk (policy_blk),
        .thr_ready  (thr_ready),
        .thr_stall  (thr_stall),
        .lat_event  (lat_event),
        .issue_sel  (issue_sel),
        .issue_vld  (issue_vld),
        .ctx_switch (ctx_switch)
    );

    task automatic chk(input string req, input logic [3:0] e_sel, input logic e_vld,
                       input logic e_ctx);
        n_chk++;
        if (issue_sel !== e_sel || issue_vld !== e_vld || ctx_switch !== e_ctx) begin
            n_fail++;
            $display("FAIL %s: sel=%b vld=%b ctx=%b expected sel=%b vld=%b ctx=%b",
                     req, issue_sel, issue_vld, ctx_switch, e_sel, e_vld, e_ctx);
        end
    endtask

    task automatic step(input logic m, input logic [3:0] r, input logic [3:0] s,
                        input logic e);
        @(negedge clk);
        policy_blk = m; thr_ready = r; thr_stall = s; lat_event = e;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; policy_blk = 1'b0; thr_ready = '0; thr_stall = '0; lat_event = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R9", 4'b0000, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_rotate();
        do_reset();
        step(0, 4'b1111, 4'b0000, 0); chk("R2", 4'b0001, 1, 1);
        step(0, 4'b1111, 4'b0000, 0); chk("R2", 4'b0010, 1, 1);
        step(0, 4'b1111, 4'b0000, 0); chk("R2", 4'b0100, 1, 1);
        step(0, 4'b1111, 4'b0000, 0); chk("R2", 4'b1000, 1, 1);
        step(0, 4'b1111, 4'b0000, 0); chk("R2", 4'b0001, 1, 1);
    endtask

    task automatic t_skip();
        do_reset();
        step(0, 4'b1111, 4'b0100, 0); chk("R3", 4'b0001, 1, 1);
        step(0, 4'b1111, 4'b0100, 0); chk("R3", 4'b0010, 1, 1);
        step(0, 4'b1111, 4'b0100, 0); chk("R3", 4'b1000, 1, 1);
        step(0, 4'b1111, 4'b0100, 0); chk("R3", 4'b0001, 1, 1);
        step(0, 4'b1101, 4'b0000, 0); chk("R3", 4'b0100, 1, 1);
    endtask

    task automatic t_single_idle();
        do_reset();
        step(0, 4'b0100, 4'b0000, 0); chk("R8", 4'b0100, 1, 1);
        step(0, 4'b0100, 4'b0000, 0); chk("R8", 4'b0100, 1, 0);
        step(0, 4'b0000, 4'b0000, 0); chk("R7", 4'b0000, 0, 0);
        step(0, 4'b1111, 4'b1111, 0); chk("R7", 4'b0000, 0, 0);
        step(0, 4'b1111, 4'b0000, 0); chk("R7", 4'b1000, 1, 1);
    endtask

    task automatic t_run_hold();
        do_reset();
        step(1, 4'b1111, 4'b0000, 0); chk("R4", 4'b0001, 1, 1);
        step(1, 4'b1111, 4'b0000, 0); chk("R4", 4'b0001, 1, 0);
        step(1, 4'b1111, 4'b0000, 0); chk("R4", 4'b0001, 1, 0);
        step(1, 4'b1111, 4'b0000, 1); chk("R5", 4'b0010, 1, 1);
    endtask

    task automatic t_event_park();
        do_reset();
        step(1, 4'b0011, 4'b0000, 0); chk("R4", 4'b0001, 1, 1);
        step(1, 4'b0011, 4'b0000, 1); chk("R5", 4'b0010, 1, 1);
        step(1, 4'b0011, 4'b0000, 1); chk("R6", 4'b0000, 0, 0);
        step(1, 4'b0011, 4'b0000, 0); chk("R6", 4'b0001, 1, 1);
        step(1, 4'b0011, 4'b0000, 0); chk("R4", 4'b0001, 1, 0);
        step(1, 4'b0011, 4'b0001, 1); chk("R5", 4'b0010, 1, 1);
        step(1, 4'b0011, 4'b0001, 0); chk("R4", 4'b0010, 1, 0);
        step(1, 4'b0011, 4'b0001, 1); chk("R6", 4'b0000, 0, 0);
        step(1, 4'b0011, 4'b0000, 0); chk("R6", 4'b0000, 0, 0);
        step(1, 4'b0011, 4'b0000, 0); chk("R6", 4'b0001, 1, 1);
    endtask

    task automatic t_idle_event();
        do_reset();
        step(1, 4'b0001, 4'b0000, 0); chk("R10", 4'b0001, 1, 1);
        step(1, 4'b0000, 4'b0000, 0); chk("R7", 4'b0000, 0, 0);
        step(1, 4'b0001, 4'b0000, 1); chk("R10", 4'b0001, 1, 0);
    endtask

    initial begin
        rst = 1'b1; policy_blk = 1'b0; thr_ready = '0; thr_stall = '0; lat_event = 1'b0;
        t_rotate();
        t_skip();
        t_single_idle();
        t_run_hold();
        t_event_park();
        t_idle_event();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule